// File: doc/BRIEF.md
# Multiplexed Boot ROM Bus Sequencer

This block runs one access at a time to a byte-wide boot memory, or to an external byte register, over a narrow shared bus. A host presents an 18-bit byte address, a read/write flag and a write byte together with `req_valid`. The sequencer then runs three bus cycles: a first address cycle, a second address cycle and a data cycle. During the two address cycles a strobe line pulses so that two external latches can capture the address and the control levels. On a read, the returned byte is presented on `rdata` together with a one-clock `done` pulse.

Each bus cycle lasts `CYC_CLKS` clocks. The 8-bit bus carries the address and the control levels, and the write byte on a write. Bit 0 of a 2-bit side line carries the two highest address bits, one in each address cycle. Bit 1 of the side line is the latch strobe. In the data cycle the side line carries the two lowest address bits and the active-low chip enable is asserted.

The states are IDLE, ADR1, ADR2, DATA and DONE. The transitions are:
- IDLE→ADR1 when `req_valid` is seen.
- ADR1→ADR2, ADR2→DATA and DATA→DONE when the phase timer reaches its last clock.
- DONE→IDLE always.

Top module: `bootbus_seq`

## Requirements
- R1: After reset the block is idle: `busy`=0, `done`=0, `ce_n`=1, `bus_oe`=0, `line_a`=0.
- R2: `req_valid` sampled high in IDLE starts an access that keeps `busy` high for 3*CYC_CLKS+1 clocks. `req_valid` and the request fields are ignored while `busy` is high.
- R3: In ADR1, `bus_out[7:2]` = addr[7:2], `bus_out[1]` = output-enable level (0 on a read, 1 on a write) and `bus_out[0]` = write-enable level (0 on a write, 1 on a read). `line_a[0]` = addr[16].
- R4: In ADR2, `bus_out` = addr[15:8] and `line_a[0]` = addr[17].
- R5: `line_a[1]` is high in the final clock of ADR1 and in the final clock of ADR2. It is low in every other clock of those two cycles.
- R6: `ce_n` is low in every clock of DATA and high in every other state. In DATA, `line_a` = addr[1:0].
- R7: In DATA on a write, `bus_oe`=1 and `bus_out` = the write byte.
- R8: In DATA on a read, `bus_oe`=0. `bus_in` is sampled at the clock edge that ends DATA.
- R9: `done` is high for exactly one clock, the clock after DATA. On a read, `rdata` holds the sampled byte in that clock. `busy` falls in the clock after `done`.
- R10: `bus_oe` is 1 throughout ADR1 and ADR2, and 0 in IDLE and DONE.
- R11: `rdata` changes only when a read completes. A write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start request, taken only in IDLE |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | High from acceptance until after DONE |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Last byte read |
| bus_out | output | 8 | Multiplexed bus output value |
| bus_oe | output | 1 | Bus output enable |
| bus_in | input | 8 | Multiplexed bus input value |
| line_a | output | 2 | Side line: bit 1 latch strobe, bit 0 high address bit |
| ce_n | output | 1 | Active-low chip enable |

## Verification
Call the accepting edge E. The outputs for clock k of the access are due in the clock that starts k edges after E, for k from 0 to 3*CYC_CLKS-1. Of these, the first CYC_CLKS clocks are ADR1, the next CYC_CLKS are ADR2 and the last CYC_CLKS are DATA. `done` and the read byte are due in the clock that follows the edge ending DATA, and `busy` is low one clock later. The bench compares every output in every clock of each access at the falling edge. Its expected values are worked out from the phase index and the clock index inside the phase. While the access runs, it keeps `req_valid` high with unrelated fields, so that any restart or field leak shows up in the next compare.

// File: rtl/bootbus_pkg.sv
package bootbus_pkg;
    localparam int ADDR_W = 18;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADR1,
        ST_ADR2,
        ST_DATA,
        ST_DONE
    } bb_state_t;
endpackage

// File: rtl/bootbus_timer.sv
module bootbus_timer #(
    parameter int CYC_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CNT_W = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(CYC_CLKS - 1);

    logic [CNT_W-1:0] cnt;

    assign last = run && (cnt == LAST_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (cnt == '0));
endmodule

// File: rtl/bootbus_fsm.sv
module bootbus_fsm
    import bootbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              last,
    output bb_state_t         state,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              lat_write,
    output logic [DATA_W-1:0] lat_wdata,
    output logic              run,
    output logic              busy,
    output logic              done
);
    bb_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req_valid) nxt = ST_ADR1;
            ST_ADR1: if (last) nxt = ST_ADR2;
            ST_ADR2: if (last) nxt = ST_DATA;
            ST_DATA: if (last) nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lat_addr  <= '0;
            lat_write <= 1'b0;
            lat_wdata <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && req_valid) begin
                lat_addr  <= req_addr;
                lat_write <= req_write;
                lat_wdata <= req_wdata;
            end
        end
    end

    always_comb begin
        run  = (state == ST_ADR1) || (state == ST_ADR2) || (state == ST_DATA);
        busy = (state != ST_IDLE);
        done = (state == ST_DONE);
    end

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
    // R2
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(lat_addr) && $stable(lat_write));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);
endmodule

// File: rtl/bootbus_drive.sv
module bootbus_drive
    import bootbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bb_state_t         state,
    input  logic              last,
    input  logic [ADDR_W-1:0] lat_addr,
    input  logic              lat_write,
    input  logic [DATA_W-1:0] lat_wdata,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [1:0]        line_a,
    output logic              ce_n,
    output logic [DATA_W-1:0] rdata
);
    logic oe_lvl;
    logic we_lvl;

    assign oe_lvl = lat_write;
    assign we_lvl = !lat_write;

    always_comb begin
        bus_out = '0;
        bus_oe  = 1'b0;
        line_a  = 2'b00;
        ce_n    = 1'b1;
        unique case (state)
            ST_ADR1: begin
                bus_out = {lat_addr[7:2], oe_lvl, we_lvl};
                bus_oe  = 1'b1;
                line_a  = {last, lat_addr[16]};
            end
            ST_ADR2: begin
                bus_out = lat_addr[15:8];
                bus_oe  = 1'b1;
                line_a  = {last, lat_addr[17]};
            end
            ST_DATA: begin
                ce_n   = 1'b0;
                line_a = lat_addr[1:0];
                if (lat_write) begin
                    bus_out = lat_wdata;
                    bus_oe  = 1'b1;
                end
            end
            ST_IDLE, ST_DONE: begin
                bus_oe = 1'b0;
            end
            default: begin
                bus_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (state == ST_DATA && last && !lat_write) begin
            rdata <= bus_in;
        end
    end

    // R11
    rdata_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata != $past(rdata)) |-> (state == ST_DONE));
endmodule

// File: rtl/bootbus_seq.sv
module bootbus_seq
    import bootbus_pkg::*;
#(
    parameter int CYC_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] bus_in,
    output logic [1:0]        line_a,
    output logic              ce_n
);
    bb_state_t         state;
    logic              last;
    logic              run;
    logic [ADDR_W-1:0] lat_addr;
    logic              lat_write;
    logic [DATA_W-1:0] lat_wdata;

    bootbus_timer #(.CYC_CLKS(CYC_CLKS)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .last (last)
    );

    bootbus_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .last     (last),
        .state    (state),
        .lat_addr (lat_addr),
        .lat_write(lat_write),
        .lat_wdata(lat_wdata),
        .run      (run),
        .busy     (busy),
        .done     (done)
    );

    bootbus_drive u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .last     (last),
        .lat_addr (lat_addr),
        .lat_write(lat_write),
        .lat_wdata(lat_wdata),
        .bus_in   (bus_in),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe),
        .line_a   (line_a),
        .ce_n     (ce_n),
        .rdata    (rdata)
    );

    // R6
    done_after_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(!ce_n));
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_oe && ce_n);
endmodule

// File: tb/sim_bootbus_seq.sv
module sim_bootbus_seq;
    localparam int CLK_P = 10;
    localparam int CYC   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done, bus_oe, ce_n;
    logic [7:0]  rdata, bus_out;
    logic [7:0]  bus_in = '0;
    logic [1:0]  line_a;

    int checks = 0;
    int errors = 0;
    logic [7:0] last_read = '0;

    always #(CLK_P/2) clk = ~clk;

    bootbus_seq #(.CYC_CLKS(CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
        .line_a(line_a), .ce_n(ce_n)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic access(logic [17:0] a, logic wr, logic [7:0] wd, logic [7:0] rv);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        bus_in    = wr ? ~wd : rv;
        @(posedge clk);
        @(negedge clk);
        // R2: junk request held during the access must be ignored
        req_write = ~wr;
        req_addr  = ~a;
        req_wdata = ~wd;
        for (int i = 0; i < 3*CYC; i++) begin
            int ph = i / CYC;
            logic lst = ((i % CYC) == CYC - 1);
            if (i != 0) @(negedge clk);
            chk("R2 busy", busy, 1);
            chk("R9 done low", done, 0);
            if (ph == 0) begin
                chk("R3 adr1 bus", bus_out, {a[7:2], wr, !wr});
                chk("R10 adr1 oe", bus_oe, 1);
                chk("R5 R3 adr1 line", line_a, {lst, a[16]});
                chk("R6 adr1 ce", ce_n, 1);
            end else if (ph == 1) begin
                chk("R4 adr2 bus", bus_out, a[15:8]);
                chk("R10 adr2 oe", bus_oe, 1);
                chk("R5 R4 adr2 line", line_a, {lst, a[17]});
                chk("R6 adr2 ce", ce_n, 1);
            end else begin
                chk("R6 data ce", ce_n, 0);
                chk("R6 data line", line_a, a[1:0]);
                if (wr) begin
                    chk("R7 data oe", bus_oe, 1);
                    chk("R7 data bus", bus_out, wd);
                end else begin
                    chk("R8 data oe", bus_oe, 0);
                end
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (!wr) last_read = rv;
        chk("R9 done pulse", done, 1);
        chk("R10 done oe", bus_oe, 0);
        chk("R9 R11 rdata", rdata, last_read);
        @(negedge clk);
        chk("R9 busy falls", busy, 0);
        chk("R9 done single", done, 0);
        chk("R11 rdata hold", rdata, last_read);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 ce_n", ce_n, 1);
        chk("R1 oe", bus_oe, 0);
        chk("R1 line_a", line_a, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", busy, 0);
        for (int b = 0; b < 18; b++) begin
            access(18'(1) << b, 1'b0, 8'h00, 8'((b * 29 + 7) & 8'hFF));
            access(18'(1) << b, 1'b1, 8'((b * 17 + 3) & 8'hFF), 8'h00);
        end
        access(18'h2A5A5, 1'b0, 8'h00, 8'hC3);
        access(18'h15A5A, 1'b1, 8'h3C, 8'h00);
        access(18'h3FFFF, 1'b0, 8'h00, 8'hFF);
        access(18'h00000, 1'b1, 8'h81, 8'h00);
        access(18'h00000, 1'b0, 8'h00, 8'h00);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule